// File: doc/BRIEF.md
# Descriptor-chained DMA controller

This block copies 32-bit words from one memory region to another without processor involvement. A single pulse on `cfg_start` begins a job. In plain mode the job takes its source address, destination address and word count straight from the configuration inputs. In chained mode the job takes only a pointer to a descriptor in memory. The controller reads each descriptor, performs the copy it describes and follows the descriptor's link to the next one. When the last copy is finished it pulses an interrupt.

The memory bus is shared with the processor. The controller asks for the bus with `bus_req` and drives it only while `bus_gnt` answers. Three ownership policies set how often it hands the bus back:
- single element: one element per ownership;
- burst: up to four elements per ownership;
- whole job: the bus is held until the job ends.

An optional demand mode paces every element on a peripheral request line.

Top module: `dma_chain_ctrl`

## Requirements
- R1: In plain mode (`cfg_chain`=0), `cfg_size` words are copied from `cfg_src` to `cfg_dst`. Each element reads one word at the source and then writes it to the destination, and both addresses step by 4 bytes per element.
- R2: In chained mode (`cfg_chain`=1), each descriptor is four 32-bit words at pointer, pointer+4, pointer+8 and pointer+12. These hold the word count, the source, the destination and the next pointer. Descriptors are executed in list order, and a next pointer of 0 ends the list.
- R3: A word count of 0 causes no copy. A plain job of size 0 makes no memory access and still raises the interrupt. A zero-size descriptor in a chain is skipped.
- R4: The memory strobes `mem_cs_n`, `mem_rd_n` and `mem_wr_n` are active low. `mem_rd_n` and `mem_wr_n` are never low together. Read data returns in the cycle after the read strobe, and that same word is written in the cycle after the read strobe.
- R5: `mem_cs_n` is low only in cycles where both `bus_req` and `bus_gnt` are high.
- R6: With `cfg_mode`=0, at most one element is performed per ownership, and `bus_req` is low in the cycle after every write strobe.
- R7: With `cfg_mode`=1, at most four elements are performed per ownership. The bus is released after the fourth element, even when that element ends a descriptor.
- R8: With `cfg_mode`=2 (and 3), once `bus_req` is raised during a job it stays high until the job has completed.
- R9: With `cfg_demand`=1, a data read strobe occurs only in a cycle where `pace_req` is high. Descriptor reads are not paced.
- R10: `busy` is high from the cycle after an accepted start until the job ends. `irq` is a single-cycle pulse, given exactly once per job.
- R11: A `cfg_start` pulse while `busy` is high is ignored, and the memory it names stays untouched.
- R12: After `bus_req` falls, it stays low for at least one further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Start pulse, accepted when idle |
| cfg_chain | input | 1 | 1: fetch descriptors from `cfg_desc_ptr` |
| cfg_mode | input | 2 | Bus ownership: 0 single element, 1 burst of four, 2/3 whole job |
| cfg_demand | input | 1 | 1: pace data reads on `pace_req` |
| cfg_src | input | 32 | Plain-mode source byte address |
| cfg_dst | input | 32 | Plain-mode destination byte address |
| cfg_size | input | 16 | Plain-mode word count |
| cfg_desc_ptr | input | 32 | Chained-mode first descriptor address |
| pace_req | input | 1 | Peripheral pacing request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read strobe |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read enable, active low |
| mem_wr_n | output | 1 | Write enable, active low |
| busy | output | 1 | Job in progress |
| irq | output | 1 | Completion pulse |

## Verification
A descriptor can end on the same write strobe that completes a burst of four. In that cycle the release of the bus and the move to the next descriptor fetch coincide, and the fetch then has to win the bus back on a fresh request. The case is provoked by burst-mode chains with descriptor sizes 4 and 8, and by random chains whose sizes often sum to multiples of four, under a randomly delayed grant. It is judged by these checks:
- the largest number of writes seen in one ownership is exactly four;
- no access happens outside a grant;
- the destination memory matches a bench copy model.

// File: rtl/dma_chain_pkg.sv
`timescale 1ns/1ps
package dma_chain_pkg;
  typedef enum logic [1:0] {
    OWN_BYTE  = 2'd0,
    OWN_BURST = 2'd1,
    OWN_BLOCK = 2'd2
  } own_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHK,
    S_RD,
    S_WR,
    S_DONE
  } seq_state_e;

  localparam int unsigned DESC_WORDS = 4;
endpackage

// File: rtl/dma_bus_owner.sv
`timescale 1ns/1ps
module dma_bus_owner
  import dma_chain_pkg::*;
#(
  parameter int unsigned BURST_LEN = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      job_active,
  input  logic      need_bus,
  input  logic      elem_done,
  input  own_mode_e mode,
  input  logic      bus_gnt,
  output logic      bus_req,
  output logic      granted
);
  localparam int unsigned BCW = $clog2(BURST_LEN + 1);
  localparam logic [BCW-1:0] BLAST = BCW'(BURST_LEN - 1);

  logic           req_q, req_d;
  logic           gap_q, gap_d;
  logic [BCW-1:0] cnt_q, cnt_d;
  logic           release_now;

  always_comb begin
    case (mode)
      OWN_BYTE:  release_now = elem_done;
      OWN_BURST: release_now = elem_done && (cnt_q == BLAST);
      default:   release_now = 1'b0;
    endcase
  end

  always_comb begin
    req_d = req_q;
    gap_d = gap_q;
    cnt_d = cnt_q;
    if (!job_active) begin
      req_d = 1'b0;
      gap_d = 1'b0;
      cnt_d = '0;
    end else if (req_q) begin
      if (release_now) begin
        req_d = 1'b0;
        gap_d = 1'b1;
        cnt_d = '0;
      end else if (elem_done && mode == OWN_BURST) begin
        cnt_d = cnt_q + BCW'(1);
      end
    end else if (gap_q) begin
      gap_d = 1'b0;
    end else if (need_bus) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      gap_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      gap_q <= gap_d;
      cnt_q <= cnt_d;
    end
  end

  assign bus_req = req_q;
  assign granted = req_q & bus_gnt;

  AST_JOB_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !job_active) |=> !bus_req); // R8
endmodule

// File: rtl/dma_chain_seq.sv
`timescale 1ns/1ps
module dma_chain_seq
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_chain,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_demand,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_size,
  input  logic [AW-1:0] cfg_desc_ptr,
  input  logic          pace_req,
  input  logic          granted,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          need_bus,
  output logic          job_active,
  output logic          elem_done,
  output own_mode_e     mode_o,
  output logic          busy,
  output logic          irq
);
  localparam logic [AW-1:0] STEP     = AW'(DW / 8);
  localparam int unsigned   FIW      = $clog2(DESC_WORDS) + 1;
  localparam logic [FIW-1:0] FIDX_END = FIW'(DESC_WORDS);

  seq_state_e     state_q, state_d;
  logic [AW-1:0]  src_q, src_d, dst_q, dst_d, ptr_q, ptr_d, next_q, next_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [FIW-1:0] fidx_q, fidx_d, slot;
  logic           pend_q, pend_d;
  logic [1:0]     mode_q, mode_d;
  logic           demand_q, demand_d, chain_q, chain_d;
  logic           rd_s, wr_s, chain_more;

  assign chain_more = chain_q && (next_q != '0);
  assign slot       = fidx_q - FIW'(1);

  always_comb begin
    state_d  = state_q;
    src_d    = src_q;
    dst_d    = dst_q;
    ptr_d    = ptr_q;
    next_d   = next_q;
    cnt_d    = cnt_q;
    fidx_d   = fidx_q;
    pend_d   = pend_q;
    mode_d   = mode_q;
    demand_d = demand_q;
    chain_d  = chain_q;
    rd_s      = 1'b0;
    wr_s      = 1'b0;
    elem_done = 1'b0;
    irq       = 1'b0;
    mem_addr  = src_q;
    case (state_q)
      S_IDLE: begin
        if (cfg_start) begin
          mode_d   = cfg_mode;
          demand_d = cfg_demand;
          chain_d  = cfg_chain;
          if (cfg_chain) begin
            ptr_d   = cfg_desc_ptr;
            fidx_d  = '0;
            pend_d  = 1'b0;
            state_d = S_FETCH;
          end else begin
            src_d   = cfg_src;
            dst_d   = cfg_dst;
            cnt_d   = cfg_size;
            next_d  = '0;
            state_d = S_CHK;
          end
        end
      end
      S_FETCH: begin
        mem_addr = ptr_q + (AW'(fidx_q) * STEP);
        rd_s     = granted && (fidx_q < FIDX_END);
        if (pend_q) begin
          case (slot)
            FIW'(0): cnt_d  = mem_rdata[CW-1:0];
            FIW'(1): src_d  = AW'(mem_rdata);
            FIW'(2): dst_d  = AW'(mem_rdata);
            default: next_d = AW'(mem_rdata);
          endcase
        end
        pend_d = rd_s;
        if (rd_s) fidx_d = fidx_q + FIW'(1);
        if (pend_q && fidx_q == FIDX_END) state_d = S_CHK;
      end
      S_CHK: begin
        if (cnt_q == '0) begin
          if (chain_more) begin
            ptr_d   = next_q;
            fidx_d  = '0;
            pend_d  = 1'b0;
            state_d = S_FETCH;
          end else begin
            state_d = S_DONE;
          end
        end else begin
          state_d = S_RD;
        end
      end
      S_RD: begin
        mem_addr = src_q;
        rd_s     = granted && (!demand_q || pace_req);
        if (rd_s) state_d = S_WR;
      end
      S_WR: begin
        mem_addr  = dst_q;
        wr_s      = 1'b1;
        elem_done = 1'b1;
        src_d     = src_q + STEP;
        dst_d     = dst_q + STEP;
        cnt_d     = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          if (chain_more) begin
            ptr_d   = next_q;
            fidx_d  = '0;
            pend_d  = 1'b0;
            state_d = S_FETCH;
          end else begin
            state_d = S_DONE;
          end
        end else begin
          state_d = S_RD;
        end
      end
      S_DONE: begin
        irq     = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      ptr_q    <= '0;
      next_q   <= '0;
      cnt_q    <= '0;
      fidx_q   <= '0;
      pend_q   <= 1'b0;
      mode_q   <= 2'd0;
      demand_q <= 1'b0;
      chain_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      src_q    <= src_d;
      dst_q    <= dst_d;
      ptr_q    <= ptr_d;
      next_q   <= next_d;
      cnt_q    <= cnt_d;
      fidx_q   <= fidx_d;
      pend_q   <= pend_d;
      mode_q   <= mode_d;
      demand_q <= demand_d;
      chain_q  <= chain_d;
    end
  end

  always_comb begin
    case (state_q)
      S_FETCH: need_bus = (fidx_q < FIDX_END);
      S_RD:    need_bus = !demand_q || pace_req;
      S_WR:    need_bus = 1'b1;
      default: need_bus = 1'b0;
    endcase
  end

  assign job_active = (state_q == S_FETCH) || (state_q == S_CHK) ||
                      (state_q == S_RD) || (state_q == S_WR);
  assign busy      = (state_q != S_IDLE);
  assign mem_rd_n  = !rd_s;
  assign mem_wr_n  = !wr_s;
  assign mem_cs_n  = !(rd_s || wr_s);
  assign mem_wdata = mem_rdata;
  assign mode_o    = own_mode_e'(mode_q);

  AST_PACE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RD && !mem_rd_n && demand_q) |-> pace_req); // R9
  AST_ZERO_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CHK && cnt_q == '0 && !chain_q) |=> (irq && mem_cs_n)); // R3
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_n) |-> $past(state_q == S_RD && !mem_rd_n)); // R4
endmodule

// File: rtl/dma_chain_ctrl.sv
`timescale 1ns/1ps
module dma_chain_ctrl
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned DW        = 32,
  parameter int unsigned CW        = 16,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start,
  input  logic          cfg_chain,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_demand,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_size,
  input  logic [AW-1:0] cfg_desc_ptr,
  input  logic          pace_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          busy,
  output logic          irq
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       granted, need_bus, job_active, elem_done;
  own_mode_e  mode_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  dma_chain_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .cfg_start    (cfg_start),
    .cfg_chain    (cfg_chain),
    .cfg_mode     (cfg_mode),
    .cfg_demand   (cfg_demand),
    .cfg_src      (cfg_src),
    .cfg_dst      (cfg_dst),
    .cfg_size     (cfg_size),
    .cfg_desc_ptr (cfg_desc_ptr),
    .pace_req     (pace_req),
    .granted      (granted),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_cs_n     (mem_cs_n),
    .mem_rd_n     (mem_rd_n),
    .mem_wr_n     (mem_wr_n),
    .need_bus     (need_bus),
    .job_active   (job_active),
    .elem_done    (elem_done),
    .mode_o       (mode_cur),
    .busy         (busy),
    .irq          (irq)
  );

  dma_bus_owner #(.BURST_LEN(BURST_LEN)) u_own (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .job_active (job_active),
    .need_bus   (need_bus),
    .elem_done  (elem_done),
    .mode       (mode_cur),
    .bus_gnt    (bus_gnt),
    .bus_req    (bus_req),
    .granted    (granted)
  );

  AST_BUS_OWNED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!mem_cs_n) |-> (bus_req && bus_gnt)); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!mem_rd_n && !mem_wr_n) && (mem_cs_n == (mem_rd_n && mem_wr_n))); // R4
  AST_BYTE_RELEASE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_cur == OWN_BYTE && !mem_wr_n) |=> !bus_req); // R6
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(bus_req) |=> !bus_req); // R12
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_cur == OWN_BLOCK && $fell(bus_req)) |-> !busy); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |=> !irq); // R10
endmodule

// File: tb/dma_chain_ctrl_test.sv
`timescale 1ns/1ps
module dma_chain_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_start, cfg_chain, cfg_demand;
  logic [1:0]  cfg_mode;
  logic [31:0] cfg_src, cfg_dst, cfg_desc_ptr;
  logic [15:0] cfg_size;
  logic        pace_req, bus_req, bus_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_cs_n, mem_rd_n, mem_wr_n, busy, irq;

  always #2.5 clk = ~clk;

  dma_chain_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_chain(cfg_chain),
    .cfg_mode(cfg_mode), .cfg_demand(cfg_demand), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_size(cfg_size), .cfg_desc_ptr(cfg_desc_ptr),
    .pace_req(pace_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .busy(busy), .irq(irq)
  );

  // memory and backdoor port
  logic [31:0] mem [256];
  logic [31:0] ref_mem [256];
  logic        bd_we;
  logic [7:0]  bd_addr;
  logic [31:0] bd_data;
  logic        pace_mode;

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr] <= bd_data;
    else if (!mem_cs_n && !mem_wr_n) mem[mem_addr[9:2]] <= mem_wdata;
    if (!mem_cs_n && !mem_rd_n) mem_rdata <= mem[mem_addr[9:2]];
  end

  // arbiter with random grant latency, and pacing source
  always @(posedge clk) begin
    if (!rst_n || !bus_req) bus_gnt <= 1'b0;
    else if (!bus_gnt)      bus_gnt <= (($urandom % 3) == 0);
    pace_req <= pace_mode ? (($urandom % 4) == 0) : 1'b1;
  end

  // monitor
  logic mon_clr;
  int   cur_mode;
  bit   cur_demand;
  int   n_acc, n_wr, n_irq, v_own, v_strobe, v_pace, v_byte, v_blk, v_gap, max_tw, ten_wr;
  bit   prev_req, prev_wr, prev_fell;

  always @(negedge clk) begin
    if (mon_clr) begin
      n_acc = 0; n_wr = 0; n_irq = 0; v_own = 0; v_strobe = 0; v_pace = 0;
      v_byte = 0; v_blk = 0; v_gap = 0; max_tw = 0; ten_wr = 0;
    end else begin
      if (bus_req && !prev_req) ten_wr = 0;
      if (!mem_cs_n) n_acc++;
      if (!mem_cs_n && !(bus_req && bus_gnt)) v_own++;
      if (!mem_rd_n && !mem_wr_n) v_strobe++;
      if (cur_demand && !mem_cs_n && !mem_rd_n && mem_addr < 32'h300 && !pace_req) v_pace++;
      if (!mem_cs_n && !mem_wr_n) begin
        n_wr++;
        ten_wr++;
        if (ten_wr > max_tw) max_tw = ten_wr;
      end
      if (prev_wr && cur_mode == 0 && bus_req) v_byte++;
      if (prev_req && !bus_req && busy) v_blk++;
      if (prev_fell && bus_req) v_gap++;
      if (irq) n_irq++;
    end
    prev_fell = prev_req && !bus_req;
    prev_req  = bus_req;
    prev_wr   = !mem_cs_n && !mem_wr_n;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic bd_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = 8'(idx); bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
    ref_mem[idx] = d;
  endtask

  int d_sz[3], d_src[3], d_dst[3];

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic run_job(input bit chain, input int nd, input int mode,
                         input bit demand, input bit mid_start, input string tag);
    int ne, to, mism;
    ne = 0;
    for (int i = 0; i < nd; i++) begin
      if (chain) begin
        bd_write(192 + 4*i,     32'(d_sz[i]));
        bd_write(192 + 4*i + 1, 32'(d_src[i] * 4));
        bd_write(192 + 4*i + 2, 32'(d_dst[i] * 4));
        bd_write(192 + 4*i + 3, (i < nd - 1) ? 32'((192 + 4*(i+1)) * 4) : 32'd0);
      end
      for (int k = 0; k < d_sz[i]; k++) ref_mem[d_dst[i] + k] = ref_mem[d_src[i] + k];
      ne += d_sz[i];
    end
    @(negedge clk);
    pace_mode = demand; cur_mode = mode; cur_demand = demand; mon_clr = 1'b1;
    @(negedge clk);
    mon_clr      = 1'b0;
    cfg_chain    = chain;
    cfg_mode     = 2'(mode);
    cfg_demand   = demand;
    cfg_src      = 32'(d_src[0] * 4);
    cfg_dst      = 32'(d_dst[0] * 4);
    cfg_size     = 16'(d_sz[0]);
    cfg_desc_ptr = 32'(192 * 4);
    cfg_start    = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(busy == 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    if (mid_start) begin
      repeat (3) @(negedge clk);
      cfg_chain = 1'b0; cfg_src = 32'd0; cfg_dst = 32'(180 * 4); cfg_size = 16'd4;
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
    end
    to = 0;
    while (busy && to < 5000) begin
      @(negedge clk);
      to++;
    end
    chk(to < 5000, "R10", {tag, " job completion cycles"}, to, 0);
    repeat (4) @(negedge clk);
    chk(n_irq == 1, "R10", {tag, " irq pulses"}, n_irq, 1);
    chk(v_own == 0, "R5", {tag, " access without grant"}, v_own, 0);
    chk(v_strobe == 0 && v_gap == 0, "R4", {tag, " strobe clash / R12 request gap"},
        v_strobe + v_gap, 0);
    chk(n_wr == ne, "R1", {tag, " element writes"}, n_wr, ne);
    if (demand) chk(v_pace == 0, "R9", {tag, " unpaced data read"}, v_pace, 0);
    if (ne == 0 && !chain) chk(n_acc == 0, "R3", {tag, " accesses on size 0"}, n_acc, 0);
    if (mode == 0) begin
      chk(max_tw == min_i(1, ne) && v_byte == 0, "R6", {tag, " writes per ownership"},
          max_tw, min_i(1, ne));
    end else if (mode == 1) begin
      chk(max_tw == min_i(4, ne), "R7", {tag, " writes per ownership"}, max_tw, min_i(4, ne));
    end else begin
      chk(max_tw == ne && v_blk == 0, "R8", {tag, " writes per ownership"}, max_tw, ne);
    end
    mism = 0;
    for (int w = 0; w < 192; w++) if (mem[w] !== ref_mem[w]) mism++;
    chk(mism == 0, mid_start ? "R11" : (chain ? "R2" : "R1"), {tag, " memory mismatches"},
        mism, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; cfg_start = 1'b0; cfg_chain = 1'b0; cfg_mode = 2'd0; cfg_demand = 1'b0;
    cfg_src = '0; cfg_dst = '0; cfg_size = '0; cfg_desc_ptr = '0;
    bd_we = 1'b0; bd_addr = '0; bd_data = '0; pace_mode = 1'b0; mon_clr = 1'b1;
    cur_mode = 0; cur_demand = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req && mem_cs_n && mem_rd_n && mem_wr_n, "R5", "reset bus idle", bus_req, 0);
    chk(!busy && !irq, "R10", "reset busy/irq", {busy, irq}, 0);
    for (int w = 0; w < 256; w++) bd_write(w, $urandom);

    // R1 plain copy, whole-job ownership
    d_sz[0] = 5; d_src[0] = 3; d_dst[0] = 70;
    run_job(1'b0, 1, 2, 1'b0, 1'b0, "R1 plain");
    // R3 plain size zero
    d_sz[0] = 0; d_src[0] = 10; d_dst[0] = 90;
    run_job(1'b0, 1, 0, 1'b0, 1'b0, "R3 zero");
    // R2/R3 chain with a zero-size middle descriptor
    d_sz[0] = 3; d_src[0] = 20; d_dst[0] = 100;
    d_sz[1] = 0; d_src[1] = 30; d_dst[1] = 110;
    d_sz[2] = 4; d_src[2] = 40; d_dst[2] = 120;
    run_job(1'b1, 3, 1, 1'b0, 1'b0, "R2 chain skip");
    // R6/R9 single-element ownership under demand pacing
    d_sz[0] = 6; d_src[0] = 50; d_dst[0] = 130;
    run_job(1'b0, 1, 0, 1'b1, 1'b0, "R6 demand");
    // R7 burst boundary coinciding with descriptor end
    d_sz[0] = 4; d_src[0] = 1;  d_dst[0] = 140;
    d_sz[1] = 8; d_src[1] = 12; d_dst[1] = 150;
    run_job(1'b1, 2, 1, 1'b0, 1'b0, "R7 burst edge");
    // R8 whole-job ownership across chain and pacing
    d_sz[0] = 5; d_src[0] = 7;  d_dst[0] = 64;
    d_sz[1] = 3; d_src[1] = 33; d_dst[1] = 80;
    run_job(1'b1, 2, 2, 1'b1, 1'b0, "R8 block");
    // R11 start while busy ignored (alternate destination words 180..183)
    d_sz[0] = 6; d_src[0] = 44; d_dst[0] = 160;
    run_job(1'b0, 1, 0, 1'b0, 1'b1, "R11 restart");

    for (int j = 0; j < 24; j++) begin
      int nd, base;
      bit ch;
      ch   = ($urandom % 2) == 1;
      nd   = ch ? 1 + int'($urandom % 3) : 1;
      base = 64 + int'($urandom % 90);
      for (int i = 0; i < nd; i++) begin
        d_sz[i]  = int'($urandom % 7);
        d_src[i] = int'($urandom % 58);
        d_dst[i] = base;
        base    += d_sz[i];
      end
      run_job(ch, nd, int'($urandom % 3), ($urandom % 2) == 1, 1'b0, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule